// File: doc/BRIEF.md
# Graphics Pattern Bank Translator with Swappable Layout

This block turns a 13-bit graphics-bus address covering the 8 KiB pattern window into a wider graphics memory address built from 1 KiB units. Six byte-wide bank registers and one layout bit, all loaded by CPU writes to a small register window, set which memory unit each 1 KiB slot of the window shows. A seventh write location also sets a horizontal/vertical nametable mirroring flag that goes to the nametable logic next to the block.

The pattern window is split into a lower half (0x0000-0x0FFF) and an upper half (0x1000-0x1FFF). One half holds two 2 KiB regions, each driven by one register whose low bit is ignored. The other half holds four 1 KiB slots driven by the other four registers. The layout bit chooses which half gets which arrangement. Address translation is purely combinational, so a graphics fetch sees the new address in the same cycle. Only the register file is clocked.

Top module: `gfx_bank_xlat`

## Requirements
- R1: After reset every bank register is 0, the layout is mode 0 and `mirror_vert_o` is 0 (horizontal).
- R2: A write strobe with `cpu_addr_i` equal to `REG_BASE + k` for k in 0..5 loads bank register k with all eight bits of `cpu_data_i`.
- R3: In mode 0, graphics addresses 0x0000-0x07FF use register 0 and 0x0800-0x0FFF use register 1, each as a 2 KiB region.
- R4: In mode 0, the 1 KiB slots at 0x1000, 0x1400, 0x1800 and 0x1C00 use registers 2, 3, 4 and 5 in that order.
- R5: In mode 1, registers 2, 3, 4 and 5 drive the 1 KiB slots at 0x0000, 0x0400, 0x0800 and 0x0C00, and registers 0 and 1 drive 2 KiB regions at 0x1000 and 0x1800.
- R6: In a 2 KiB region the first 1 KiB uses the register value with bit 0 cleared and the second 1 KiB uses that value plus one, so the register's bit 0 has no effect.
- R7: A write to `REG_BASE + 6` sets `mirror_vert_o` from data bit 0 (1 = vertical) and the layout mode from data bit 1 (1 = mode 1). Bits 7..2 have no effect.
- R8: `gfx_addr_o` equals {unit, `ppu_addr_i[9:0]`}, where unit is the selected bank value modulo `NUM_UNITS`. It follows `ppu_addr_i` combinationally, with no clock edge.
- R9: Writes to addresses outside `REG_BASE` .. `REG_BASE + 6`, and cycles with the write strobe low, change no register and no output.
- R10: A register write takes effect at the rising clock edge that samples the strobe. Before that edge the output still reflects the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | CPU_AW (16) | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, one clock per write |
| ppu_addr_i | input | 13 | Graphics-bus address in the pattern window |
| gfx_addr_o | output | UNIT_AW+10 (18) | Graphics memory byte address |
| mirror_vert_o | output | 1 | Mirroring selection: 1 vertical, 0 horizontal |

## Verification
The bench goes after the half swap. A design that mixes up the mode test would give the upper slots the 2 KiB registers, and the bench catches this with distinct values in all six registers, checked in both modes. Odd values in the 2 KiB registers expose a design that keeps bit 0, or that adds one to the wrong half. Writes one location past the control register, and writes with the strobe held low, expose loose address decode. A build with a unit count that is not a power of two exposes modulo reduction done as plain truncation. A check made just before and just after the write edge exposes a register stage added on the output path, or a write path that bypasses the register.

// File: rtl/gfx_bank_pkg.sv
package gfx_bank_pkg;
  localparam int NUM_BANK_REGS = 6;
  localparam int CTRL_OFF      = 6;
  localparam int UNIT_OFF_W    = 10;  // 1 KiB
  localparam int SLOT_W        = 3;   // 8 slots of 1 KiB
  localparam int NUM_SLOTS     = 1 << SLOT_W;
  localparam int BYTE_W        = 8;

  typedef logic [BYTE_W-1:0] bank_byte_t;

  typedef struct packed {
    logic mode;
    logic mirror_vert;
  } gfx_ctrl_t;
endpackage

// File: rtl/gfx_bank_regs.sv
module gfx_bank_regs
  import gfx_bank_pkg::*;
#(
  parameter int          CPU_AW   = 16,
  parameter logic [15:0] REG_BASE = 16'h7EF0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [CPU_AW-1:0]                   cpu_addr_i,
  input  bank_byte_t                          cpu_data_i,
  input  logic                                cpu_we_i,
  output logic [NUM_BANK_REGS-1:0][BYTE_W-1:0] banks_o,
  output gfx_ctrl_t                           ctrl_o
);
  logic [CPU_AW-1:0] off;
  assign off = cpu_addr_i - CPU_AW'(REG_BASE);

  for (genvar k = 0; k < NUM_BANK_REGS; k++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                banks_o[k] <= '0;
      else if (cpu_we_i && off == CPU_AW'(k))     banks_o[k] <= cpu_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else if (cpu_we_i && off == CPU_AW'(CTRL_OFF)) begin
      ctrl_o.mirror_vert <= cpu_data_i[0];
      ctrl_o.mode        <= cpu_data_i[1];
    end
  end
endmodule

// File: rtl/gfx_slot_sel.sv
module gfx_slot_sel
  import gfx_bank_pkg::*;
(
  input  logic [NUM_BANK_REGS-1:0][BYTE_W-1:0] banks_i,
  input  logic                                mode_i,
  input  logic [SLOT_W-1:0]                   slot_i,
  output bank_byte_t                          bank_o
);
  bank_byte_t slot_bank [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int  HALF = s / 4;
    localparam int  PAIR = (s / 2) % 2;
    localparam int  QUAD = s % 4;
    localparam logic SUB = 1'(s % 2);
    always_comb begin
      // half holding the 2 KiB regions is the one whose index equals mode
      if (mode_i == 1'(HALF)) slot_bank[s] = {banks_i[PAIR][BYTE_W-1:1], SUB};
      else                    slot_bank[s] = banks_i[2 + QUAD];
    end
  end

  assign bank_o = slot_bank[slot_i];
endmodule

// File: rtl/gfx_unit_wrap.sv
module gfx_unit_wrap
  import gfx_bank_pkg::*;
#(
  parameter int NUM_UNITS = 256,
  localparam int UNIT_AW  = $clog2(NUM_UNITS)
) (
  input  bank_byte_t         bank_i,
  output logic [UNIT_AW-1:0] unit_o
);
  if ((NUM_UNITS & (NUM_UNITS - 1)) == 0) begin : g_pow2
    assign unit_o = UNIT_AW'(bank_i);
  end else begin : g_mod
    assign unit_o = UNIT_AW'(32'(bank_i) % NUM_UNITS);
  end
endmodule

// File: rtl/gfx_bank_xlat.sv
module gfx_bank_xlat
  import gfx_bank_pkg::*;
#(
  parameter int          CPU_AW    = 16,
  parameter logic [15:0] REG_BASE  = 16'h7EF0,
  parameter int          NUM_UNITS = 256,
  localparam int         UNIT_AW   = $clog2(NUM_UNITS),
  localparam int         GFX_AW    = UNIT_AW + UNIT_OFF_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [CPU_AW-1:0]                  cpu_addr_i,
  input  logic [BYTE_W-1:0]                  cpu_data_i,
  input  logic                               cpu_we_i,
  input  logic [SLOT_W+UNIT_OFF_W-1:0]       ppu_addr_i,
  output logic [GFX_AW-1:0]                  gfx_addr_o,
  output logic                               mirror_vert_o
);
  logic [NUM_BANK_REGS-1:0][BYTE_W-1:0] banks;
  gfx_ctrl_t                           ctrl;
  bank_byte_t                          sel_bank;
  logic [UNIT_AW-1:0]                  unit;

  gfx_bank_regs #(.CPU_AW(CPU_AW), .REG_BASE(REG_BASE)) regs_i (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i,
    .banks_o(banks), .ctrl_o(ctrl)
  );

  gfx_slot_sel sel_i (
    .banks_i(banks), .mode_i(ctrl.mode),
    .slot_i(ppu_addr_i[SLOT_W+UNIT_OFF_W-1:UNIT_OFF_W]), .bank_o(sel_bank)
  );

  gfx_unit_wrap #(.NUM_UNITS(NUM_UNITS)) wrap_i (
    .bank_i(sel_bank), .unit_o(unit)
  );

  assign gfx_addr_o    = {unit, ppu_addr_i[UNIT_OFF_W-1:0]};
  assign mirror_vert_o = ctrl.mirror_vert;
endmodule

// File: rtl/gfx_bank_xlat_chk.sv
module gfx_bank_xlat_chk #(
  parameter int          CPU_AW    = 16,
  parameter logic [15:0] REG_BASE  = 16'h7EF0,
  parameter int          NUM_UNITS = 256,
  parameter int          GFX_AW    = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CPU_AW-1:0] cpu_addr_i,
  input logic              wr_bit0_i,
  input logic              cpu_we_i,
  input logic [12:0]       ppu_addr_i,
  input logic [GFX_AW-1:0] gfx_addr_o,
  input logic              mirror_vert_o
);
  logic ctrl_wr;
  assign ctrl_wr = cpu_we_i && (cpu_addr_i == CPU_AW'(REG_BASE + 16'd6));

  a_r7_mirror_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> mirror_vert_o == $past(wr_bit0_i));

  a_r9_mirror_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(mirror_vert_o));

  a_r8_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gfx_addr_o[9:0] == ppu_addr_i[9:0]);

  a_r8_unit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(gfx_addr_o[GFX_AW-1:10]) < NUM_UNITS);

  a_r10_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cpu_we_i) && $stable(ppu_addr_i)) |-> $stable(gfx_addr_o));
endmodule

bind gfx_bank_xlat gfx_bank_xlat_chk #(
  .CPU_AW(CPU_AW), .REG_BASE(REG_BASE), .NUM_UNITS(NUM_UNITS), .GFX_AW(GFX_AW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i),
  .wr_bit0_i(cpu_data_i[0]), .cpu_we_i(cpu_we_i), .ppu_addr_i(ppu_addr_i),
  .gfx_addr_o(gfx_addr_o), .mirror_vert_o(mirror_vert_o)
);

// File: tb/gfx_bank_xlat_tb_top.sv
module gfx_bank_xlat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_we_i = 1'b0;
  logic [12:0] ppu_addr_i = '0;
  logic [17:0] gfx_addr_o, gfx_mod_o;
  logic        mirror_vert_o, mirror_mod_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gfx_bank_xlat dut_i (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i,
    .gfx_addr_o(gfx_addr_o), .mirror_vert_o(mirror_vert_o)
  );

  gfx_bank_xlat #(.NUM_UNITS(200)) dut_mod_i (
    .clk_i, .rst_ni, .cpu_addr_i, .cpu_data_i, .cpu_we_i, .ppu_addr_i,
    .gfx_addr_o(gfx_mod_o), .mirror_vert_o(mirror_mod_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_we_i = 1'b1;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  // set graphics address between edges and compare after settling
  task automatic look(input string req, input logic [12:0] a, input logic [7:0] bank);
    ppu_addr_i = a; #1;
    chk(req, 32'(gfx_addr_o), 32'({bank, a[9:0]}));
  endtask

  task automatic t_reset;
    chk("R1 mirror", 32'(mirror_vert_o), 0);
    look("R1 slot 0x1FFF", 13'h1FFF, 8'h00);
    look("R1 R6 second half 0x0C05", 13'h0C05, 8'h01);
    look("R1 mode0 first", 13'h0000, 8'h00);
  endtask

  task automatic t_mode0;
    cpu_wr(16'h7EF0, 8'h04); cpu_wr(16'h7EF1, 8'h07);
    cpu_wr(16'h7EF2, 8'h12); cpu_wr(16'h7EF3, 8'h23);
    cpu_wr(16'h7EF4, 8'h34); cpu_wr(16'h7EF5, 8'hF5);
    look("R3 R6 reg0 lo", 13'h0000, 8'h04);
    look("R3 R6 reg0 hi", 13'h07FF, 8'h05);
    look("R3 R6 reg1 odd lo", 13'h0800, 8'h06);
    look("R3 R6 reg1 odd hi", 13'h0C00, 8'h07);
    look("R4 R2 0x1000", 13'h1000, 8'h12);
    look("R4 R2 0x1400", 13'h1400, 8'h23);
    look("R4 R2 0x1800", 13'h1800, 8'h34);
    look("R4 R2 0x1FFF", 13'h1FFF, 8'hF5);
  endtask

  task automatic t_mode1;
    cpu_wr(16'h7EF6, 8'h02);
    chk("R7 mode1 mirror horiz", 32'(mirror_vert_o), 0);
    look("R5 0x0000", 13'h0000, 8'h12);
    look("R5 0x0400", 13'h0400, 8'h23);
    look("R5 0x0800", 13'h0800, 8'h34);
    look("R5 0x0C00", 13'h0C00, 8'hF5);
    look("R5 R6 0x1000", 13'h1000, 8'h04);
    look("R5 R6 0x1400", 13'h1400, 8'h05);
    look("R5 R6 0x1800", 13'h1800, 8'h06);
    look("R5 R6 0x1FFF", 13'h1FFF, 8'h07);
  endtask

  task automatic t_ctrl;
    cpu_wr(16'h7EF6, 8'h03);
    chk("R7 vertical", 32'(mirror_vert_o), 1);
    look("R7 still mode1", 13'h0400, 8'h23);
    cpu_wr(16'h7EF6, 8'h01);
    chk("R7 vertical mode0", 32'(mirror_vert_o), 1);
    look("R7 back to mode0", 13'h1000, 8'h12);
    cpu_wr(16'h7EF6, 8'hFC);
    chk("R7 upper bits ignored mirror", 32'(mirror_vert_o), 0);
    look("R7 upper bits ignored mode", 13'h0000, 8'h04);
  endtask

  task automatic t_ignore;
    cpu_wr(16'h7EF7, 8'hFF);
    cpu_wr(16'h7EEF, 8'hFF);
    cpu_wr(16'hFEF0, 8'hFF);
    cpu_wr(16'h6EF6, 8'hFF);
    @(negedge clk_i);
    cpu_addr_i = 16'h7EF6; cpu_data_i = 8'hFF; cpu_we_i = 1'b0;
    @(negedge clk_i);
    cpu_addr_i = 16'h7EF0;
    @(negedge clk_i);
    chk("R9 mirror unchanged", 32'(mirror_vert_o), 0);
    look("R9 reg0 unchanged", 13'h0000, 8'h04);
    look("R9 reg5 unchanged", 13'h1C00, 8'hF5);
    look("R9 mode unchanged", 13'h1000, 8'h12);
  endtask

  task automatic t_timing;
    ppu_addr_i = 13'h1000;
    @(negedge clk_i);
    cpu_addr_i = 16'h7EF2; cpu_data_i = 8'h55; cpu_we_i = 1'b1;
    #1;
    chk("R10 before edge", 32'(gfx_addr_o), 32'({8'h12, 10'h000}));
    @(posedge clk_i); #1;
    chk("R10 after edge", 32'(gfx_addr_o), 32'({8'h55, 10'h000}));
    @(negedge clk_i);
    cpu_we_i = 1'b0;
    ppu_addr_i = 13'h13AB; #1;
    chk("R8 comb offset", 32'(gfx_addr_o), 32'({8'h55, 10'h3AB}));
    ppu_addr_i = 13'h0123; #1;
    chk("R8 comb slot change", 32'(gfx_addr_o), 32'({8'h04, 10'h123}));
  endtask

  task automatic t_modulo;
    cpu_wr(16'h7EF5, 8'hFF);
    cpu_wr(16'h7EF0, 8'hC9);
    ppu_addr_i = 13'h1C10; #1;
    chk("R8 mod 255%200", 32'(gfx_mod_o), 32'({8'd55, 10'h010}));
    chk("R8 pow2 passthrough", 32'(gfx_addr_o), 32'({8'hFF, 10'h010}));
    ppu_addr_i = 13'h0000; #1;
    chk("R8 R6 mod 200%200", 32'(gfx_mod_o), 32'({8'd0, 10'h000}));
    ppu_addr_i = 13'h0400; #1;
    chk("R8 R6 mod 201%200", 32'(gfx_mod_o), 32'({8'd1, 10'h000}));
    look("R6 0xC9 second half", 13'h0400, 8'hC9);
  endtask

  task automatic t_reset_again;
    cpu_wr(16'h7EF6, 8'h03);
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    chk("R1 async clear mirror", 32'(mirror_vert_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    look("R1 mode0 after reset", 13'h1000, 8'h00);
    look("R1 reg0 after reset", 13'h0400, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mode0();
    t_mode1();
    t_ctrl();
    t_ignore();
    t_timing();
    t_modulo();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule